// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit connects a 64-bit load/store datapath to a byte-addressable memory bus that is 64 bits wide. A request carries an address, an access size, a direction, an endianness select and, for loads, a signed flag.

For a store, the unit moves the operand bytes onto the bus lanes picked by the low address bits and raises the matching byte write enables. For a load, it takes the addressed bytes out of the bus word in the selected byte order and extends them to 64 bits.

A request that breaks natural alignment for its size is not split into smaller accesses. It is reported through a fault output and has no effect: no write enable is raised and no load data is returned. Every result appears one clock after its request, on registered outputs.

Top module: `lsu_lane_align`

## Requirements
- R1: The cycle after `req_valid_i` is sampled high, `rsp_valid_o` is high. The cycle after it is sampled low, `rsp_valid_o`, `fault_o` and `mem_be_o` are all zero. While reset is asserted, every output is zero.
- R2: `size_i` encodes 0 = byte, 1 = half word, 2 = word and 3 = double word. `fault_o` rises with `rsp_valid_o` when the access is misaligned: a half word with `addr_i[0]` set, a word with `addr_i[1:0]` nonzero, or a double word with `addr_i[2:0]` nonzero. A byte access never faults.
- R3: A faulting access drives `mem_be_o`, `mem_wdata_o` and `load_data_o` to zero.
- R4: Little-endian store (`big_endian_i`=0): byte k of the operand, counting k=0 as the least significant, goes to bus lane `addr_i[2:0]`+k. Bus lane i is `mem_wdata_o[8i+7:8i]`. Address bits above bit 2 have no effect on lane placement.
- R5: Big-endian store (`big_endian_i`=1): the most significant operand byte goes to lane `addr_i[2:0]`, and the following lanes take bytes of falling significance. A word 0x01234567 stored at offset 4 puts 01, 23, 45, 67 in lanes 4 to 7.
- R6: For an aligned store of n bytes, `mem_be_o` has exactly bits `addr_i[2:0]` to `addr_i[2:0]`+n-1 set. Lanes without an enable carry zero data. A load never raises any bit of `mem_be_o`.
- R7: Little-endian load: result byte k is read from bus lane `addr_i[2:0]`+k of `mem_rdata_i`.
- R8: Big-endian load: the byte in lane `addr_i[2:0]` becomes the most significant byte of the result. A double-word load at offset 0 therefore returns the bus word with its bytes in reverse order.
- R9: With `signed_i` high, a byte, half-word or word load is sign-extended to 64 bits. With `signed_i` low, it is zero-extended. A double-word load is returned without extension. Store responses return `load_data_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_store_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | 64 | Byte address |
| size_i | input | 2 | Access size code (see R2) |
| big_endian_i | input | 1 | 1 = big-endian byte order |
| signed_i | input | 1 | Sign-extend load result |
| wdata_i | input | 64 | Store operand, right-justified |
| mem_rdata_i | input | 64 | Bus word read from memory for a load |
| rsp_valid_o | output | 1 | Result valid, one cycle after request |
| fault_o | output | 1 | Misaligned access reported |
| mem_be_o | output | 8 | Per-lane write enables |
| mem_wdata_o | output | 64 | Lane-placed store data |
| load_data_o | output | 64 | Extended load result |

## Verification
On every cycle, the assertions check the request-to-response timing and the silence of idle cycles. They also check that a fault never comes with write enables or load data, and that a byte access never faults. A byte store has to raise a single enable, a load none, and an aligned double-word store all eight.

The exact byte placement for each order and offset, the fault rule for each size, and the sign or zero extension are shown only by the bench. It compares every response against a reference model written from shifts and byte reversal. Directed cases cover the endianness example and the alignment boundaries, and seeded random traffic covers the rest.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  localparam int unsigned BUS_W  = 64;
  localparam int unsigned LANES  = BUS_W / 8;
  localparam int unsigned OFF_W  = $clog2(LANES);
  localparam int unsigned SIZE_W = 2;
endpackage

// File: rtl/lsu_align_chk.sv
module lsu_align_chk
  import lsu_align_pkg::*;
(
  input  logic [OFF_W-1:0]  off_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              misaligned_o
);
  logic [OFF_W-1:0] low_mask;

  // bits of the offset that must be zero for natural alignment
  always_comb begin
    low_mask = '0;
    for (int b = 0; b < int'(OFF_W); b++)
      if (b < int'(size_i)) low_mask[b] = 1'b1;
  end

  assign misaligned_o = |(off_i & low_mask);
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_align_pkg::*;
(
  input  logic [OFF_W-1:0]  off_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              big_i,
  input  logic [BUS_W-1:0]  data_i,
  output logic [BUS_W-1:0]  lane_data_o,
  output logic [LANES-1:0]  lane_en_o
);
  int nbytes;
  int rel;
  int src;

  always_comb begin
    nbytes      = 1 << size_i;
    lane_data_o = '0;
    lane_en_o   = '0;
    rel         = 0;
    src         = 0;
    for (int i = 0; i < int'(LANES); i++) begin
      rel = i - int'(off_i);
      if (rel >= 0 && rel < nbytes) begin
        src = big_i ? (nbytes - 1 - rel) : rel;
        lane_data_o[8*i +: 8] = data_i[8*src +: 8];
        lane_en_o[i]          = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_align_pkg::*;
(
  input  logic [OFF_W-1:0]  off_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              big_i,
  input  logic              signed_i,
  input  logic [BUS_W-1:0]  bus_i,
  output logic [BUS_W-1:0]  value_o
);
  logic [BUS_W-1:0] raw;
  logic             sign_bit;
  int               nbytes;
  int               lane;

  always_comb begin
    nbytes = 1 << size_i;
    raw    = '0;
    lane   = 0;
    for (int k = 0; k < int'(LANES); k++) begin
      if (k < nbytes) begin
        lane = big_i ? (int'(off_i) + nbytes - 1 - k) : (int'(off_i) + k);
        if (lane < int'(LANES)) raw[8*k +: 8] = bus_i[8*lane +: 8];
      end
    end
    sign_bit = signed_i & raw[8*nbytes-1];
    value_o  = raw;
    for (int b = 0; b < int'(BUS_W); b++)
      if (b >= 8*nbytes) value_o[b] = sign_bit;
  end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_align_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_store_i,
  input  logic [63:0]       addr_i,
  input  logic [1:0]        size_i,
  input  logic              big_endian_i,
  input  logic              signed_i,
  input  logic [63:0]       wdata_i,
  input  logic [63:0]       mem_rdata_i,
  output logic              rsp_valid_o,
  output logic              fault_o,
  output logic [7:0]        mem_be_o,
  output logic [63:0]       mem_wdata_o,
  output logic [63:0]       load_data_o
);
  logic [OFF_W-1:0] off;
  logic             misaligned;
  logic [BUS_W-1:0] st_data;
  logic [LANES-1:0] st_en;
  logic [BUS_W-1:0] ld_value;
  logic             do_store;
  logic             do_load;

  assign off = addr_i[OFF_W-1:0];

  lsu_align_chk u_chk (
    .off_i        (off),
    .size_i       (size_i),
    .misaligned_o (misaligned)
  );

  lsu_store_lane u_store (
    .off_i       (off),
    .size_i      (size_i),
    .big_i       (big_endian_i),
    .data_i      (wdata_i),
    .lane_data_o (st_data),
    .lane_en_o   (st_en)
  );

  lsu_load_extract u_load (
    .off_i    (off),
    .size_i   (size_i),
    .big_i    (big_endian_i),
    .signed_i (signed_i),
    .bus_i    (mem_rdata_i),
    .value_o  (ld_value)
  );

  assign do_store = req_valid_i &  req_store_i & ~misaligned;
  assign do_load  = req_valid_i & ~req_store_i & ~misaligned;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      fault_o     <= 1'b0;
      mem_be_o    <= '0;
      mem_wdata_o <= '0;
      load_data_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      fault_o     <= req_valid_i & misaligned;
      mem_be_o    <= do_store ? st_en   : '0;
      mem_wdata_o <= do_store ? st_data : '0;
      load_data_o <= do_load  ? ld_value : '0;
    end
  end

  a_r1_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && !fault_o && mem_be_o == '0));

  a_r3_fault_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (mem_be_o == '0 && load_data_o == '0 && mem_wdata_o == '0));

  a_r2_byte_never_faults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && size_i == SZ_BYTE) |=> !fault_o);

  a_r6_load_no_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_store_i) |=> mem_be_o == '0);

  a_r6_byte_store_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_store_i && size_i == SZ_BYTE) |=> $onehot(mem_be_o));

  a_r6_dword_store_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_store_i && size_i == SZ_DWORD && addr_i[2:0] == 3'd0)
      |=> (&mem_be_o));
endmodule

// File: tb/tb_lsu_lane_align.sv
`timescale 1ns/1ps
module tb_lsu_lane_align;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        req_valid_i, req_store_i, big_endian_i, signed_i;
  logic [63:0] addr_i, wdata_i, mem_rdata_i;
  logic [1:0]  size_i;
  logic        rsp_valid_o, fault_o;
  logic [7:0]  mem_be_o;
  logic [63:0] mem_wdata_o, load_data_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  lsu_lane_align dut (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] nmask(int nb);
    return (nb == 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'h1 << (8*nb)) - 64'h1);
  endfunction

  function automatic logic [63:0] rev_n(logic [63:0] v, int nb);
    logic [63:0] r = '0;
    for (int j = 0; j < nb; j++) r[8*(nb-1-j) +: 8] = v[8*j +: 8];
    return r;
  endfunction

  task automatic req(bit st, logic [63:0] a, logic [1:0] sz, bit be, bit sg,
                     logic [63:0] wd, logic [63:0] rd);
    int nb, off;
    bit mis;
    logic [63:0] v, e_wd, e_ld;
    logic [7:0]  e_be;
    @(negedge clk_i);
    req_valid_i = 1; req_store_i = st; addr_i = a; size_i = sz;
    big_endian_i = be; signed_i = sg; wdata_i = wd; mem_rdata_i = rd;
    nb  = 1 << sz;
    off = int'(a[2:0]);
    mis = (off % nb) != 0;
    e_wd = '0; e_be = '0; e_ld = '0;
    if (!mis && st) begin
      v = wd & nmask(nb);
      if (be) v = rev_n(v, nb);
      e_wd = v << (8*off);
      e_be = 8'(((16'h1 << nb) - 16'h1) << off);
    end
    if (!mis && !st) begin
      v = (rd >> (8*off)) & nmask(nb);
      if (be) v = rev_n(v, nb);
      if (sg && nb < 8 && v[8*nb-1]) v = v | ~nmask(nb);
      e_ld = v;
    end
    @(negedge clk_i);
    req_valid_i = 0;
    chk("R1 rsp_valid", 64'(rsp_valid_o), 64'd1);
    chk("R2 fault", 64'(fault_o), 64'(mis));
    chk(mis ? "R3 be" : (st ? "R6 be" : "R6 load be"), 64'(mem_be_o), 64'(e_be));
    chk(be ? "R5 wdata" : "R4 wdata", mem_wdata_o, e_wd);
    chk(be ? "R8 load" : (sg ? "R9 load" : "R7 load"), load_data_o, e_ld);
  endtask

  initial begin
    req_valid_i = 0; req_store_i = 0; addr_i = '0; size_i = '0;
    big_endian_i = 0; signed_i = 0; wdata_i = '0; mem_rdata_i = '0;
    rst_ni = 0;
    repeat (3) @(negedge clk_i);
    chk("R1 reset rsp", 64'(rsp_valid_o), 0);
    chk("R1 reset be", 64'(mem_be_o), 0);
    chk("R1 reset fault", 64'(fault_o), 0);
    rst_ni = 1;
    @(negedge clk_i);
    // R5 / R4 endianness example, word at offset 4
    req(1, 64'h104, 2'd2, 1, 0, 64'h0123_4567, '0);
    chk("R5 example", mem_wdata_o, 64'h6745_2301_0000_0000);
    req(1, 64'h104, 2'd2, 0, 0, 64'h0123_4567, '0);
    chk("R4 example", mem_wdata_o, 64'h0123_4567_0000_0000);
    // R2 / R3 misalignment boundaries
    req(1, 64'h3, 2'd1, 0, 0, 64'hBEEF, '0);
    chk("R3 odd half", 64'(mem_be_o), 0);
    req(0, 64'h2, 2'd2, 1, 1, '0, 64'hFFFF_FFFF_FFFF_FFFF);
    req(1, 64'h4, 2'd3, 0, 0, 64'h1122_3344_5566_7788, '0);
    req(1, 64'hFFFF_FFFF_FFFF_FFF7, 2'd0, 1, 0, 64'hA5, '0);
    chk("R6 byte lane7", 64'(mem_be_o), 64'h80);
    // R9 extension
    req(0, 64'h0, 2'd0, 0, 1, '0, 64'h80);
    chk("R9 signed byte", load_data_o, 64'hFFFF_FFFF_FFFF_FF80);
    req(0, 64'h0, 2'd0, 0, 0, '0, 64'h80);
    chk("R9 unsigned byte", load_data_o, 64'h80);
    req(0, 64'h6, 2'd1, 1, 1, '0, 64'h0000_0000_0000_0000 | (64'h80 << 48));
    chk("R8 signed half BE", load_data_o, 64'hFFFF_FFFF_FFFF_8000);
    // R8 double word BE reverses bytes
    req(0, 64'h0, 2'd3, 1, 1, '0, 64'h0102_0304_0506_0708);
    chk("R8 dword BE", load_data_o, 64'h0807_0605_0403_0201);
    // R1 idle cycle
    @(negedge clk_i);
    chk("R1 idle rsp", 64'(rsp_valid_o), 0);
    chk("R1 idle be", 64'(mem_be_o), 0);
    // random traffic, fixed seed
    void'($urandom(32'd20240611));
    for (int n = 0; n < 400; n++) begin
      logic [63:0] a, wd, rd;
      a  = {$urandom, $urandom};
      wd = {$urandom, $urandom};
      rd = {$urandom, $urandom};
      req(1'($urandom), a, 2'($urandom), 1'($urandom), 1'($urandom), wd, rd);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule